// File: doc/BRIEF.md
# Reset-Cause Status Register

This block is a single byte-wide, read-only status register on a simple peripheral register bus. It tells software three things: which environment straps were present when the device last came out of a hard reset, whether the flash interfaces are busy right now, and whether a watchdog reset or a software reset into in-system programming has happened since the flag was last cleared.

The reset sources are modelled as single-cycle pulse inputs. The synchronous `rst` input is the power-on reset. `ext_rst_pulse` marks an external pin reset. `wdt_rst_pulse` marks a watchdog reset. `isp_rst_pulse` marks a completed software reset into programming mode. `clr_rst_pulse` marks a completed software clear-reset sequence. The watchdog timer, the flash controller and the reset sequencer sit outside the block. Software reads the byte with a read strobe, and the data appears one cycle later. The only thing software can change is the watchdog flag, which it clears by writing 1 to it.

Top module: `rcs_status_reg`

## Requirements
- R1: A read strobe with an address match returns the status byte on `bus_rdata` one cycle later. The layout is bit 7 software-programming-reset flag, bit 6 watchdog flag, bit 5 reserved, bit 4 data-flash busy, bit 3 flash busy, bits 2:0 environment. In any cycle after one without a matching read, `bus_rdata` is 0.
- R2: Power-on reset (`rst`) and an external reset pulse load bits 2:0 from `env_pins` as they are in that cycle.
- R3: The environment bits hold their value through watchdog, software-programming and clear-sequence resets, through writes, and through changes on `env_pins`.
- R4: Bit 3 shows `flash_busy` as it was in the cycle of the read strobe.
- R5: Bit 4 shows `dflash_busy` as it was in the cycle of the read strobe.
- R6: A watchdog reset pulse sets bit 6, and the bit reads 1 afterwards.
- R7: A matching write with data bit 6 at 1 clears bit 6. A matching write with data bit 6 at 0 leaves it unchanged.
- R8: Power-on reset and an external reset pulse clear both bit 7 and bit 6.
- R9: A software-programming reset pulse sets bit 7, and a clear-sequence pulse clears it. Writes never change bit 7.
- R10: A watchdog pulse leaves bit 7 unchanged, and a software-programming or clear-sequence pulse leaves bit 6 unchanged.
- R11: Bit 5 always reads 0. A write of 0xBF changes nothing.
- R12: When a set pulse and a soft clear for the same flag arrive in the same cycle, the set wins.
- R13: A write to an address other than `REG_ADDR` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, 0 when not read |
| ext_rst_pulse | input | 1 | External reset occurred |
| wdt_rst_pulse | input | 1 | Watchdog reset occurred |
| isp_rst_pulse | input | 1 | Software reset into programming mode occurred |
| clr_rst_pulse | input | 1 | Software clear-reset sequence occurred |
| env_pins | input | 3 | Environment strap pins |
| flash_busy | input | 1 | Flash (program or data) busy |
| dflash_busy | input | 1 | Data-flash interface busy |

## Verification
Some rules are checked by assertions on every cycle:
- every watchdog pulse leaves the flag set;
- every external reset clears both flags and reloads the environment;
- the environment stays still between hard resets;
- each write-1 and clear-sequence pulse clears its flag;
- the busy bits follow their inputs with one cycle of read latency.

Other behaviour can only be shown by the bench's scenarios:
- the flags are independent of each other across long mixed sequences of resets and writes;
- a write of every bit except bit 6 has no effect;
- a simultaneous set and clear resolves in favour of the set;
- writes to a neighbouring address are ignored;
- power-on reset clears the flags.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DATA_W    = 8;
  localparam int ENV_W     = 3;
  localparam int WDT_BIT   = 6;
  localparam int NFLAG     = 2;
  localparam int FLAG_WDT  = 0;
  localparam int FLAG_ISP  = 1;

  typedef struct packed {
    logic             isp_seen;
    logic             wdt_seen;
    logic             rsv;
    logic             dflash_busy;
    logic             flash_busy;
    logic [ENV_W-1:0] env;
  } status_t;

  localparam logic [DATA_W-1:0] WDT_MASK = DATA_W'(1) << WDT_BIT;
endpackage

// File: rtl/rcs_env_latch.sv
module rcs_env_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_pulse,
  input  logic [W-1:0] pins,
  output logic [W-1:0] env_q
);
  always_ff @(posedge clk) begin
    if (rst || ext_pulse) env_q <= pins;
  end
endmodule

// File: rtl/rcs_sticky_flag.sv
module rcs_sticky_flag (
  input  logic clk,
  input  logic hard_clr,
  input  logic set_pulse,
  input  logic soft_clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (hard_clr)       flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (soft_clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/rcs_read_port.sv
module rcs_read_port
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  status_t           stat,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= stat;
    else             rdata <= '0;
  end
endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
  import rcs_pkg::*;
#(
  parameter int                 ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_rst_pulse,
  input  logic              wdt_rst_pulse,
  input  logic              isp_rst_pulse,
  input  logic              clr_rst_pulse,
  input  logic [ENV_W-1:0]  env_pins,
  input  logic              flash_busy,
  input  logic              dflash_busy
);
  logic             addr_hit, wr_hit, rd_hit, hard_clr, wdt_w1c;
  logic [ENV_W-1:0] env_q;
  logic [NFLAG-1:0] flag_set, flag_soft, flag_q;
  logic             wdt_flag, isp_flag;
  status_t          stat;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr && addr_hit;
  assign rd_hit   = bus_rd && addr_hit;
  assign hard_clr = rst || ext_rst_pulse;
  assign wdt_w1c  = wr_hit && ((bus_wdata & WDT_MASK) != '0);

  assign flag_set[FLAG_WDT]  = wdt_rst_pulse;
  assign flag_soft[FLAG_WDT] = wdt_w1c;
  assign flag_set[FLAG_ISP]  = isp_rst_pulse;
  assign flag_soft[FLAG_ISP] = clr_rst_pulse;

  rcs_env_latch #(.W(ENV_W)) u_env (
    .clk(clk), .rst(rst), .ext_pulse(ext_rst_pulse),
    .pins(env_pins), .env_q(env_q)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    rcs_sticky_flag u_flag (
      .clk(clk), .hard_clr(hard_clr), .set_pulse(flag_set[g]),
      .soft_clr(flag_soft[g]), .flag(flag_q[g])
    );
  end

  assign wdt_flag = flag_q[FLAG_WDT];
  assign isp_flag = flag_q[FLAG_ISP];

  always_comb begin
    stat             = '0;
    stat.isp_seen    = isp_flag;
    stat.wdt_seen    = wdt_flag;
    stat.dflash_busy = dflash_busy;
    stat.flash_busy  = flash_busy;
    stat.env         = env_q;
  end

  rcs_read_port u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .stat(stat), .rdata(bus_rdata)
  );
endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk
  import rcs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h30
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ext_rst_pulse,
  input logic              wdt_rst_pulse,
  input logic              isp_rst_pulse,
  input logic              clr_rst_pulse,
  input logic [ENV_W-1:0]  env_pins,
  input logic              flash_busy,
  input logic              dflash_busy,
  input logic [ENV_W-1:0]  env_q,
  input logic              wdt_flag,
  input logic              isp_flag
);
  // R1
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == REG_ADDR) |=> bus_rdata == '0);
  // R2
  env_load_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rst_pulse |=> env_q == $past(env_pins));
  // R3
  env_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_pulse |=> $stable(env_q));
  // R4
  fbusy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_ADDR) |=> bus_rdata[3] == $past(flash_busy));
  // R5
  dbusy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_ADDR) |=> bus_rdata[4] == $past(dflash_busy));
  // R6
  wdt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst_pulse && !ext_rst_pulse) |=> wdt_flag);
  // R7
  wdt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR && bus_wdata[6] && !wdt_rst_pulse) |=> !wdt_flag);
  // R8
  hard_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rst_pulse |=> (!wdt_flag && !isp_flag));
  // R9
  isp_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_rst_pulse && !isp_rst_pulse && !ext_rst_pulse) |=> !isp_flag);
endmodule

bind rcs_status_reg rcs_status_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/sim_rcs_status_reg.sv
module sim_rcs_status_reg;
  localparam logic [7:0] RA = 8'h30;
  localparam logic [7:0] OTHER = 8'h31;

  logic clk = 1'b0;
  logic rst, bus_wr, bus_rd, ext_p, wdt_p, isp_p, clr_p, fb, db;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0] env_pins;
  int checks = 0, fails = 0;
  logic [2:0] exp_env;

  always #2.5 clk = ~clk;

  rcs_status_reg u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_rst_pulse(ext_p),
    .wdt_rst_pulse(wdt_p), .isp_rst_pulse(isp_p), .clr_rst_pulse(clr_p),
    .env_pins(env_pins), .flash_busy(fb), .dflash_busy(db)
  );

  // op codes: 0 wdt, 1 isp, 2 clear-seq, 3 write, 4 external, 5 write other address
  // entry {op, wdata, expected {bit7, bit6}}
  localparam logic [12:0] TBL [13] = '{
    {3'd0, 8'h00, 2'b01},  // R6
    {3'd3, 8'h00, 2'b01},  // R7 zero write keeps flag
    {3'd1, 8'h00, 2'b11},  // R9 R10
    {3'd3, 8'hBF, 2'b11},  // R11
    {3'd3, 8'h40, 2'b10},  // R7 R9
    {3'd0, 8'h00, 2'b11},  // R10
    {3'd2, 8'h00, 2'b01},  // R9 R10
    {3'd3, 8'hFF, 2'b00},  // R7
    {3'd1, 8'h00, 2'b10},  // R9
    {3'd4, 8'h00, 2'b00},  // R8 R2
    {3'd0, 8'h00, 2'b01},  // R6
    {3'd5, 8'h40, 2'b01},  // R13
    {3'd4, 8'h00, 2'b00}   // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; ext_p = 0; wdt_p = 0; isp_p = 0; clr_p = 0;
    bus_addr = RA; bus_wdata = 8'h00;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); idle(); bus_rd = 1;
    @(negedge clk); v = bus_rdata; bus_rd = 0;
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk); idle();
    case (op)
      3'd0: wdt_p = 1;
      3'd1: isp_p = 1;
      3'd2: clr_p = 1;
      3'd3: begin bus_wr = 1; bus_wdata = d; end
      3'd4: begin ext_p = 1; exp_env = env_pins; end
      default: begin bus_wr = 1; bus_addr = OTHER; bus_wdata = d; end
    endcase
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(); fb = 0; db = 0; rst = 1; env_pins = 3'b101; exp_env = 3'b101;
    repeat (3) @(negedge clk);
    rst = 0; env_pins = 3'b010;
    @(negedge clk);
    check("R1 idle read data", bus_rdata, 8'h00);
    rd(v);
    check("R2 R8 reset state", v, {2'b00, 3'b000, 3'b101});

    for (int i = 0; i < 13; i++) begin
      env_pins = 3'(i) ^ 3'b110;
      apply(TBL[i][12:10], TBL[i][9:2]);
      rd(v);
      check($sformatf("R3 R6 R7 R8 R9 R10 R11 R13 step %0d", i), v,
            {TBL[i][1:0], 3'b000, exp_env});
    end

    // busy pass-through
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle(); bus_rd = 1; fb = k[0]; db = k[1];
      @(negedge clk); bus_rd = 0; fb = ~fb; db = ~db;
      check("R4 R5 R11 busy bits", v & 8'h00 | bus_rdata,
            {3'b000, k[1], k[0], exp_env});
      @(negedge clk);
      check("R1 no read zero", bus_rdata, 8'h00);
    end
    fb = 0; db = 0;

    // R12 set beats clear
    @(negedge clk); idle(); wdt_p = 1; bus_wr = 1; bus_wdata = 8'h40;
    isp_p = 1; clr_p = 1;
    rd(v);
    check("R12 set wins", v & 8'hC0, 8'hC0);

    // R8 power-on reset clears flags, R2 samples pins
    env_pins = 3'b011;
    @(negedge clk); idle(); rst = 1;
    @(negedge clk); rst = 0; env_pins = 3'b100;
    rd(v);
    check("R8 R2 power-on", v, {5'b00000, 3'b011});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule